// File: doc/BRIEF.md
# Synchronous Serial Port

This block is an 8-bit serial port with a separate clock pin. It has a transmit data pin and a receive data pin. Software first picks the configuration: the port either drives the serial clock (master) or follows a clock from outside (slave). It also picks the clock polarity and whether the byte goes out most-significant bit first or least-significant bit first. Software then presents a byte and pulses `start`. The port shifts the byte out and, at the same time, collects a byte from the receive pin. At the end it shows the received byte and pulses `done`.

In master mode the serial clock comes from the system clock through an integer divider. In slave mode the external clock passes through a two-flop synchronizer and an edge detector, so the system clock has to run at least four times faster than the serial clock. With positive polarity the clock rests high, the port drives data on the falling edge and captures data on the rising edge. Negative polarity swaps both rules, and the clock rests low. When a byte ends, the transmit pin keeps the last bit it drove. A DMA request pulse is raised only in master mode.

Top module: `sync_serial_port`

## Requirements
- R1: While `busy` is low, a sampled `start` sets `busy` on the next clock. The transfer ends after the sixteenth serial clock edge: `busy` falls and `done` is high for exactly one clock. A `start` or a new `txData` value while `busy` is high has no effect on that transfer.
- R2: In master mode `sclkOut` toggles once every D system clocks, where D is `cfgDiv`, and any `cfgDiv` below 2 counts as 2. The first toggle comes D clocks after `start` is sampled.
- R3: With `cfgPolNeg`=0, `sclkOut` rests high when no transfer is running. Data moves onto `sdo` at falling edges, `sdi` is captured at rising edges, and the clock finishes high.
- R4: With `cfgPolNeg`=1, `sclkOut` rests low. Data moves onto `sdo` at rising edges, `sdi` is captured at falling edges, and the clock finishes low.
- R5: `sdo` changes only on a data-out edge. After a transfer it keeps the last bit sent until the first data-out edge of the next transfer.
- R6: With `cfgMsbFirst`=1, bit 7 of `txData` is sent first and the first bit received lands in bit 7. With `cfgMsbFirst`=0, both use bit 0 first.
- R7: `rxData` takes the full received byte in the same clock that `done` rises, and holds it at all other times.
- R8: `dmaReq` pulses together with `done` only when `cfgMaster`=1. In slave mode it stays low.
- R9: In slave mode (`cfgMaster`=0), each change of `sclkIn` counts as a serial edge on the third system clock after the change. `sclkOut` stays at its rest level.
- R10: During reset `busy`, `done`, `dmaReq`, `sdo` and `rxData` are 0, and `sclkOut` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMaster | input | 1 | 1 = port drives the serial clock, 0 = follows sclkIn |
| cfgPolNeg | input | 1 | 0 = clock rests high, 1 = clock rests low |
| cfgMsbFirst | input | 1 | 1 = bit 7 first, 0 = bit 0 first |
| cfgDiv | input | DIV_W | Master half-period in system clocks (minimum 2) |
| txData | input | 8 | Byte to send, taken at start |
| start | input | 1 | Begins a transfer when idle |
| rxData | output | 8 | Last received byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock pulse at the end of a transfer |
| dmaReq | output | 1 | One-clock DMA request at the end of a master transfer |
| sclkOut | output | 1 | Serial clock driven in master mode |
| sclkIn | input | 1 | External serial clock for slave mode |
| sdo | output | 1 | Serial transmit data |
| sdi | input | 1 | Serial receive data |

## Verification
Master transfers use both polarities, both bit orders and dividers of 0, 1, 2, 3 and 5. Together these separate a wrong rest level or wrong edge assignment, a reversed bit order, and a divider that mishandles its lower bound. The receive pin carries a new pseudo-random bit every clock, so a capture on the wrong edge or one clock off gives a different byte. One transfer receives a second start and a changed data byte while it is running, which shows whether an active transfer can be disturbed. Slave transfers with different external half-periods check the synchronizer delay, the fixed rest level of the clock output and the absence of DMA requests.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int SSP_BITS  = 8;
  localparam int SSP_EDGES = 2 * SSP_BITS;
  localparam int SSP_CNT_W = $clog2(SSP_EDGES);

  typedef struct packed {
    logic load;      // capture transmit byte
    logic shiftOut;  // drive next bit onto sdo
    logic sampleIn;  // capture sdi
    logic finish;    // last edge of the byte
  } sspStrb_t;
endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             cfgMaster,
  input  logic             cfgPolNeg,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             sclkIn,
  output sspStrb_t         strb,
  output logic             busy,
  output logic             done,
  output logic             dmaReq,
  output logic             sclkOut
);
  localparam int CNT_W = SSP_CNT_W;

  logic [DIV_W-1:0] divCnt, divEff;
  logic [CNT_W-1:0] edgeCnt;
  logic [1:0]       syncQ;
  logic             syncPrev;
  logic             idleLvl, masterTick, slaveEdge, edgeEv;

  always_comb begin
    divEff     = (cfgDiv < DIV_W'(2)) ? DIV_W'(2) : cfgDiv;
    idleLvl    = ~cfgPolNeg;
    masterTick = (divCnt == divEff - DIV_W'(1));
    slaveEdge  = syncQ[1] ^ syncPrev;
    edgeEv     = busy & (cfgMaster ? masterTick : slaveEdge);
    strb.load     = ~busy & start;
    strb.shiftOut = edgeEv & ~edgeCnt[0];
    strb.sampleIn = edgeEv & edgeCnt[0];
    strb.finish   = edgeEv & (edgeCnt == CNT_W'(SSP_EDGES - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      dmaReq   <= 1'b0;
      sclkOut  <= 1'b1;
      divCnt   <= '0;
      edgeCnt  <= '0;
      syncQ    <= '0;
      syncPrev <= 1'b0;
    end else begin
      syncQ    <= {syncQ[0], sclkIn};
      syncPrev <= syncQ[1];
      done     <= strb.finish;
      dmaReq   <= strb.finish & cfgMaster;
      if (!busy) begin
        sclkOut <= idleLvl;
        divCnt  <= '0;
        edgeCnt <= '0;
        if (start) busy <= 1'b1;
      end else begin
        divCnt <= masterTick ? '0 : divCnt + DIV_W'(1);
        if (edgeEv) begin
          edgeCnt <= edgeCnt + CNT_W'(1);
          if (cfgMaster) sclkOut <= ~sclkOut;
        end
        if (strb.finish) busy <= 1'b0;
      end
    end
  end

  // R1
  busy_end_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  // R1
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8
  dma_master_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> ($past(cfgMaster) && done));
  // R9
  slave_clk_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sclkOut) && $past(busy)) |-> $past(cfgMaster));
endmodule

// File: rtl/ssp_dp.sv
module ssp_dp
  import ssp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  sspStrb_t   strb,
  input  logic       cfgMsbFirst,
  input  logic [7:0] txData,
  input  logic       sdi,
  output logic       sdo,
  output logic [7:0] rxData
);
  logic [7:0] txShift, rxShift, rxNext;
  logic       shiftOutS, finishS;

  always_comb begin
    shiftOutS = strb.shiftOut;
    finishS   = strb.finish;
    rxNext    = cfgMsbFirst ? {rxShift[6:0], sdi} : {sdi, rxShift[7:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxData  <= '0;
      sdo     <= 1'b0;
    end else begin
      if (strb.load) txShift <= txData;
      else if (strb.shiftOut) begin
        sdo     <= cfgMsbFirst ? txShift[7] : txShift[0];
        txShift <= cfgMsbFirst ? {txShift[6:0], 1'b0} : {1'b0, txShift[7:1]};
      end
      if (strb.sampleIn) rxShift <= rxNext;
      if (strb.finish)   rxData  <= rxNext;
    end
  end

  // R5
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(shiftOutS) |-> $stable(sdo));
  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(finishS) |-> $stable(rxData));
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgMaster,
  input  logic             cfgPolNeg,
  input  logic             cfgMsbFirst,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic [7:0]       txData,
  input  logic             start,
  output logic [7:0]       rxData,
  output logic             busy,
  output logic             done,
  output logic             dmaReq,
  output logic             sclkOut,
  input  logic             sclkIn,
  output logic             sdo,
  input  logic             sdi
);
  sspStrb_t strb;

  ssp_ctrl #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgMaster(cfgMaster),
    .cfgPolNeg(cfgPolNeg), .cfgDiv(cfgDiv), .sclkIn(sclkIn), .strb(strb),
    .busy(busy), .done(done), .dmaReq(dmaReq), .sclkOut(sclkOut)
  );

  ssp_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgMsbFirst(cfgMsbFirst),
    .txData(txData), .sdi(sdi), .sdo(sdo), .rxData(rxData)
  );
endmodule

// File: tb/tb_sync_serial_port.sv
`timescale 1ns/1ps
module tb_sync_serial_port;
  logic clk = 1'b0, rstN = 1'b0;
  logic cfgMaster = 1'b1, cfgPolNeg = 1'b0, cfgMsbFirst = 1'b1;
  logic [7:0] cfgDiv = 8'd2, txData = 8'd0, rxData;
  logic start = 1'b0, busy, done, dmaReq, sclkOut, sclkIn = 1'b1, sdo, sdi;
  logic [15:0] lfsr = 16'hACE1;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit finished = 0;

  // behavioural reference state
  int mBusy, mDone, mDma, mSclk, mSdo, mRx, tick, k, half, pos, ev, slvEdge;
  logic [7:0] txByte, rxAcc;
  int hist[$];

  always #4 clk = ~clk;

  sync_serial_port #(.DIV_W(8)) dut (
    .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgPolNeg(cfgPolNeg),
    .cfgMsbFirst(cfgMsbFirst), .cfgDiv(cfgDiv), .txData(txData), .start(start),
    .rxData(rxData), .busy(busy), .done(done), .dmaReq(dmaReq),
    .sclkOut(sclkOut), .sclkIn(sclkIn), .sdo(sdo), .sdi(sdi)
  );

  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign sdi = lfsr[0];

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mDma = 0; mSclk = 1; mSdo = 0; mRx = 0;
      tick = 0; k = 0; rxAcc = 8'd0; txByte = 8'd0;
      hist.delete();
      for (int i = 0; i < 3; i++) hist.push_back(0);
    end else begin
      slvEdge = (hist[1] != hist[2]) ? 1 : 0;
      hist.push_front(int'(sclkIn));
      void'(hist.pop_back());
      mDone = 0; mDma = 0;
      half = (cfgDiv < 2) ? 2 : int'(cfgDiv);
      if (mBusy == 0) begin
        mSclk = cfgPolNeg ? 0 : 1;
        tick = 0; k = 0;
        if (start) begin mBusy = 1; txByte = txData; end
      end else begin
        ev = 0;
        if (tick == half - 1) begin tick = 0; if (cfgMaster) ev = 1; end
        else tick++;
        if (!cfgMaster && slvEdge != 0) ev = 1;
        if (ev != 0) begin
          pos = cfgMsbFirst ? 7 - k / 2 : k / 2;
          if (k % 2 == 0) mSdo = int'(txByte[pos]);
          else rxAcc[pos] = sdi;
          if (cfgMaster) mSclk = 1 - mSclk;
          k++;
          if (k == 16) begin
            mBusy = 0; mDone = 1; mDma = cfgMaster ? 1 : 0; mRx = int'(rxAcc);
          end
        end
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      vectors++;
      check("R1", "busy", int'(busy), mBusy);
      check("R1", "done", int'(done), mDone);
      check("R8", "dmaReq", int'(dmaReq), mDma);
      check("R2/R3/R4/R9", "sclkOut", int'(sclkOut), mSclk);
      check("R5/R6", "sdo", int'(sdo), mSdo);
      check("R6/R7", "rxData", int'(rxData), mRx);
    end
  end

  task automatic summary();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      miscompares++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
    end
  end

  task automatic masterXfer(input logic pol, input logic msb, input logic [7:0] div,
                            input logic [7:0] d, input bit poke);
    int eff;
    eff = (div < 2) ? 2 : int'(div);
    @(negedge clk);
    cfgMaster = 1'b1; cfgPolNeg = pol; cfgMsbFirst = msb; cfgDiv = div; txData = d;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R1: restart attempt and new data mid-transfer must be ignored
      repeat (5) @(negedge clk);
      start = 1'b1; txData = ~d;
      @(negedge clk);
      start = 1'b0;
    end
    repeat (16 * eff + 6) @(negedge clk);
  endtask

  task automatic slaveXfer(input logic pol, input logic msb, input logic [7:0] d, input int hp);
    @(negedge clk);
    cfgMaster = 1'b0; cfgPolNeg = pol; cfgMsbFirst = msb; txData = d;
    sclkIn = ~pol;
    repeat (5) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    for (int e = 0; e < 16; e++) begin
      repeat (hp) @(negedge clk);
      sclkIn = ~sclkIn;
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset values
    vectors++;
    check("R10", "busy", int'(busy), 0);
    check("R10", "done", int'(done), 0);
    check("R10", "dmaReq", int'(dmaReq), 0);
    check("R10", "sclkOut", int'(sclkOut), 1);
    check("R10", "sdo", int'(sdo), 0);
    check("R10", "rxData", int'(rxData), 0);
    rstN = 1'b1;
    masterXfer(1'b0, 1'b1, 8'd2, 8'hA5, 1'b0);  // R3 R6 msb-first
    masterXfer(1'b1, 1'b0, 8'd3, 8'h3C, 1'b1);  // R4 lsb-first, R1 ignore
    masterXfer(1'b0, 1'b0, 8'd1, 8'h81, 1'b0);  // R2 divider floor
    masterXfer(1'b1, 1'b1, 8'd5, 8'h7E, 1'b0);
    slaveXfer(1'b0, 1'b1, 8'h5A, 4);            // R9 R8 slave
    slaveXfer(1'b1, 1'b0, 8'hC3, 6);
    masterXfer(1'b0, 1'b1, 8'd0, 8'hF0, 1'b0);  // R2 zero divider, R5 hold
    summary();
  end
endmodule